// File: doc/BRIEF.md
# Ternary Stream Odd-Value Detector

This block watches a stream of base-3 digits, most significant digit first, one digit on each cycle that the valid strobe is high. After each digit it says whether the number formed by every digit accepted so far is odd. It does not build up the numeric value. Every power of three is odd, so the parity of the value is the parity of the number of digits equal to 1. The machine therefore stores only a running parity bit.

The odd answer comes out in two forms. A combinational flag shows the result that the digit now on the input would produce, in the same cycle. A registered copy holds the result of the last accepted digit. The 2-bit code 3 is not a digit. The machine ignores it for parity and raises a sticky error flag that only reset clears.

Top module: `tern_odd_det`

## Requirements
- R1: A synchronous active-high reset puts the machine in its even start state. After reset the registered odd flag and the error flag are both 0.
- R2: When the strobe is high and the digit is 1 (code 2'b01), the parity flips. Digits 0 (2'b00) and 2 (2'b10) keep the parity.
- R3: The combinational odd output equals the parity that the present strobed digit would produce. When the strobe is low it shows the stored parity.
- R4: The registered odd output changes on the rising edge after a strobed legal digit, to the value the combinational output had in that cycle.
- R5: While the strobe is low, the parity, the registered flag and the error flag all keep their values.
- R6: A strobed code 2'b11 leaves the parity and the registered flag unchanged. On the next edge it sets the error flag.
- R7: The error flag stays set through any further digits until reset.
- R8: After any sequence of legal digits, the registered flag is 1 exactly when that sequence, read as a base-3 number, is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dig_vld | input | 1 | Digit strobe |
| dig | input | 2 | Ternary digit; code 3 is illegal |
| odd_now | output | 1 | Combinational odd result for the current input |
| odd_q | output | 1 | Registered odd result of the last accepted digit |
| bad_code | output | 1 | Sticky illegal-code flag |

## Verification
The assertions assume that the strobe and the digit are known (not X) after reset. Apart from that, every input value is legal, including code 3. The stimulus drives all four codes with the strobe both high and low, and it places illegal codes in the middle of legal runs. The bench drives inputs away from the clock edge, so the inputs are stable at every sampling edge.

// File: rtl/tern_odd_pkg.sv
package tern_odd_pkg;
    localparam int DIG_W = 2;
    localparam logic [DIG_W-1:0] DIG_ZERO = 2'b00;
    localparam logic [DIG_W-1:0] DIG_ONE  = 2'b01;
    localparam logic [DIG_W-1:0] DIG_TWO  = 2'b10;
    localparam logic [DIG_W-1:0] DIG_BAD  = 2'b11;

    typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_e;

    typedef struct packed {
        par_e par;
        logic odd;
        logic err;
    } st_t;
endpackage

// File: rtl/tern_digit_class.sv
module tern_digit_class
    import tern_odd_pkg::*;
(
    input  logic [DIG_W-1:0] dig,
    output logic             flips,
    output logic             illegal
);
    always_comb begin
        flips   = 1'b0;
        illegal = 1'b0;
        case (dig)
            DIG_ONE:  flips   = 1'b1;
            DIG_BAD:  illegal = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tern_odd_det.sv
module tern_odd_det
    import tern_odd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dig_vld,
    input  logic [DIG_W-1:0] dig,
    output logic             odd_now,
    output logic             odd_q,
    output logic             bad_code
);
    st_t  st_d, st_q;
    logic flips, illegal;

    tern_digit_class u_cls (
        .dig     (dig),
        .flips   (flips),
        .illegal (illegal)
    );

    always_comb begin
        st_d = st_q;
        if (dig_vld) begin
            if (illegal) begin
                st_d.err = 1'b1;
            end else begin
                st_d.par = par_e'(st_q.par ^ flips);
                st_d.odd = st_q.par ^ flips;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{par: PAR_EVEN, odd: 1'b0, err: 1'b0};
        else     st_q <= st_d;
    end

    assign odd_now  = (dig_vld && !illegal) ? (st_q.par ^ flips) : st_q.par;
    assign odd_q    = st_q.odd;
    assign bad_code = st_q.err;
endmodule

// File: rtl/tern_odd_det_chk.sv
module tern_odd_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       dig_vld,
    input logic [1:0] dig,
    input logic       odd_now,
    input logic       odd_q,
    input logic       bad_code
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!odd_q && !bad_code)); // R1
    AST_ONE_FLIPS: assert property (@(posedge clk) disable iff (rst) (dig_vld && dig == 2'b01) |-> (odd_now != odd_q)); // R2
    AST_EVEN_KEEP: assert property (@(posedge clk) disable iff (rst) (dig_vld && (dig == 2'b00 || dig == 2'b10)) |-> (odd_now == odd_q)); // R2
    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (dig_vld && dig != 2'b11) |=> (odd_q == $past(odd_now))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !dig_vld |=> ($stable(odd_q) && $stable(bad_code))); // R5
    AST_BAD_SETS: assert property (@(posedge clk) disable iff (rst) (dig_vld && dig == 2'b11) |=> (bad_code && $stable(odd_q))); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) bad_code |=> bad_code); // R7
endmodule

bind tern_odd_det tern_odd_det_chk u_chk (.*);

// File: tb/tern_odd_det_test.sv
`timescale 1ns/1ps
module tern_odd_det_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dig_vld = 1'b0;
    logic [1:0] dig = 2'b00;
    logic odd_now, odd_q, bad_code;
    int checks = 0;
    int failures = 0;
    int ref_ones = 0;
    int ref_err = 0;
    int ref_val = 0;

    always #10 clk = ~clk;

    tern_odd_det uut (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Digits are applied at the falling edge and checked before the next rising edge.
    task automatic step(input logic v, input logic [1:0] d, input string req);
        int nxt;
        @(negedge clk);
        dig_vld = v;
        dig = d;
        #1;
        nxt = ref_ones + ((v && d == 2'd1) ? 1 : 0);
        chk({req, " R3 comb"}, odd_now, logic'(nxt % 2));
        @(posedge clk);
        if (v && d != 2'd3) begin
            ref_ones = nxt;
            ref_val = (ref_val * 3 + int'(d)) % 1024;
        end
        if (v && d == 2'd3) ref_err = 1;
        #1;
        chk({req, " R4 reg"}, odd_q, logic'(ref_ones % 2));
        chk({req, " R8 value parity"}, odd_q, logic'(ref_val % 2));
        chk({req, " R7 err"}, bad_code, logic'(ref_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dig_vld = 1'b1;
        dig = 2'd1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        dig_vld = 1'b0;
        ref_ones = 0;
        ref_err = 0;
        ref_val = 0;
        chk("R1 odd after reset", odd_q, 1'b0);
        chk("R1 err after reset", bad_code, 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                do_reset();
                step(1, 2'd1, "R2 one");
                step(1, 2'd0, "R2 zero");
                step(1, 2'd2, "R2 two");
                step(1, 2'd1, "R2 one again");
                step(0, 2'd1, "R5 idle one");
                step(0, 2'd3, "R5 idle bad");
                step(1, 2'd1, "R2 odd");
                step(1, 2'd3, "R6 bad");
                step(1, 2'd2, "R7 after bad");
                step(1, 2'd1, "R7 flip after bad");
                step(0, 2'd0, "R5 idle err");
                do_reset();
                for (int i = 0; i < 300; i++) begin
                    logic [1:0] d;
                    d = 2'((i * 7 + i / 5) % 3);
                    step((i % 4) != 3, d, "R8 stream");
                end
                step(1, 2'd3, "R6 late bad");
                do_reset();
                step(1, 2'd2, "R1 R2 after second reset");
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule